// File: doc/BRIEF.md
# Battery Charge Termination Sequencer

This block is the digital sequencing core of a linear lithium-ion charger. It does not regulate or sense anything itself. It receives comparator results that are already digitized: source-present flags for the AC and USB inputs, an AC overvoltage flag, an in-voltage-regulation flag, flags for current below the taper and termination levels, a flag for battery voltage below the recharge level, and a thermal-suspend flag. From these, a prescaled time tick and a few configuration inputs, it decides when to charge, when to stop, when to restart and when to give up with a fault.

Two tick-driven timers set the time limits. The safety timer bounds the time spent charging before taper current is seen. The taper timer sets how long the current must stay below the taper level before charge is declared complete. Both timers are switched on by a single enable bit. A thermal suspend freezes both of them. The safety timer also restarts whenever the charger drops out of voltage regulation.

A fault stops charging and selects the small detection current. It stays latched until the charger-reset command is given. The block also drives the power-good pin. By default the pin follows source validity. The host can force the pin on or off, or make it blink with a programmable on-time and period. While the charger-reset command is held, the pin goes to high impedance.

Top module: `chg_seq`

## Requirements
- R1: The state is reported on `state_o` as a 3-bit code: SLEEP=0, FAST=1, VREG=2, TAPER=3, DONE=4, FAULT=5. After reset the state is SLEEP and all status bits are 0.
- R2: A source is valid when `usb_present` is high, or when `ac_present` is high and `ac_ovp` is low. Without a valid source, every state except FAULT moves to SLEEP on the next clock. SLEEP moves to FAST when a source is valid.
- R3: FAST moves to VREG while `in_vreg` is high. VREG and TAPER move back to FAST when `in_vreg` drops, and the safety timer restarts from zero at that point.
- R4: While `cfg_timer_en` is high, the safety timer counts ticks in FAST, VREG and TAPER. It saturates at SAFE_TICKS. If the count stands at SAFE_TICKS in FAST or VREG, the next state is FAULT. This check takes precedence over the in_vreg and taper transitions.
- R5: In FAULT, `chg_en`=0, `det_cur_sel`=1 and `st_fault`=1. FAULT and `st_fault` persist whatever the inputs are, until `cfg_chg_reset` is given.
- R6: VREG moves to TAPER while `below_taper` is high. If `below_taper` drops, TAPER moves back to VREG and the taper timer clears. After TAPER_TICKS counted ticks, TAPER moves to DONE and sets `st_taper`.
- R7: In FAST, VREG or TAPER, a high `below_term` moves the state to DONE on the next clock and sets `st_term`. This holds whether or not the timers are enabled, and it takes precedence over every other transition in those states.
- R8: With `cfg_timer_en` low, neither timer advances. No fault is raised, and TAPER never ends on time.
- R9: While `therm_susp` is high, both timers hold their count without clearing. Counting resumes when the suspend ends.
- R10: In DONE, a high `below_rch` moves the state to FAST and clears `st_taper` and `st_term`. `irq` is the OR of `st_taper`, `st_term` and `st_fault`.
- R11: While `cfg_chg_reset` is high, `pg_hiz`=1 and `pg_on`=0. On the next clock the state becomes SLEEP and all status bits clear.
- R12: `pg_mode` selects the power-good behaviour: 0 follows source validity, 1 forces the pin on, 2 forces it off, 3 blinks. In blink mode a tick counter runs from 0 to `pg_period`-1 and wraps, and the pin is on while the count is below `pg_on_time`. The counter is held at 0 in the other modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Prescaled time tick, one cycle wide |
| ac_present | input | 1 | AC source above battery by margin |
| ac_ovp | input | 1 | AC source above overvoltage limit |
| usb_present | input | 1 | USB source above battery by margin |
| in_vreg | input | 1 | Charger is in voltage regulation |
| below_taper | input | 1 | Charge current below taper level |
| below_term | input | 1 | Charge current below termination level |
| below_rch | input | 1 | Battery voltage below recharge level |
| therm_susp | input | 1 | Thermal suspend active |
| cfg_timer_en | input | 1 | Enables safety and taper timers |
| cfg_chg_reset | input | 1 | Charger reset command |
| pg_mode | input | 2 | Power-good mode: follow, on, off, blink |
| pg_on_time | input | PG_W | Blink on-time in ticks |
| pg_period | input | PG_W | Blink period in ticks |
| chg_en | output | 1 | Charge current enable |
| det_cur_sel | output | 1 | Selects the small detection current |
| state_o | output | 3 | Current state code |
| st_taper | output | 1 | Terminated by taper timer |
| st_term | output | 1 | Terminated by minimum current |
| st_fault | output | 1 | Safety timer fault latched |
| irq | output | 1 | Interrupt request |
| pg_on | output | 1 | Power-good pin active |
| pg_hiz | output | 1 | Power-good pin released to high impedance |

## Verification
The hardest situation to reach from the ports is a taper-timer completion that has been interrupted. It needs a valid source, `in_vreg` and `below_taper` held together for TAPER_TICKS ticks, with thermal pauses and taper-level bounces in between, and all of it has to finish before the safety timer runs out. Random flag flips rarely hold that combination for long enough. So directed sequences first walk the charger into TAPER with the timers enabled, insert a thermal pause and a bounce back to VREG, and then let the taper timer finish. Long random stretches follow, with a low flip rate on each flag. A bench model tracks every state, timer and status bit cycle by cycle.

// File: rtl/chg_seq_pkg.sv
package chg_seq_pkg;

  parameter int PG_W = 8;

  typedef enum logic [2:0] {
    ST_SLEEP = 3'd0,
    ST_FAST  = 3'd1,
    ST_VREG  = 3'd2,
    ST_TAPER = 3'd3,
    ST_DONE  = 3'd4,
    ST_FAULT = 3'd5
  } chg_state_e;

  typedef enum logic [1:0] {
    PG_FOLLOW = 2'd0,
    PG_FORCE_ON = 2'd1,
    PG_FORCE_OFF = 2'd2,
    PG_BLINK = 2'd3
  } pg_mode_e;

  // True in the three states that drive charge current.
  function automatic logic is_charging(chg_state_e s);
    return (s == ST_FAST) || (s == ST_VREG) || (s == ST_TAPER);
  endfunction

  // True in the states that belong to the voltage-regulation phase.
  function automatic logic in_reg_phase(chg_state_e s);
    return (s == ST_VREG) || (s == ST_TAPER);
  endfunction

  // Next blink count: wraps to zero after period-1 (period 0 holds at 0).
  function automatic logic [PG_W-1:0] blink_step(logic [PG_W-1:0] cnt,
                                                 logic [PG_W-1:0] period);
    logic [PG_W:0] inc;
    inc = {1'b0, cnt} + {{PG_W{1'b0}}, 1'b1};
    if (inc >= {1'b0, period}) return '0;
    return inc[PG_W-1:0];
  endfunction

  function automatic logic blink_lit(logic [PG_W-1:0] cnt,
                                     logic [PG_W-1:0] on_time);
    return cnt < on_time;
  endfunction

endpackage

// File: rtl/chg_seq_timer.sv
module chg_seq_timer #(
  parameter int W = 16,
  parameter int unsigned LIMIT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic expired
);

  localparam logic [W-1:0] TERM = W'(LIMIT);

  logic [W-1:0] cnt;
  logic         at_term;

  assign at_term = (cnt == TERM);
  assign expired = at_term;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (clr)               cnt <= '0;
    else if (run && !at_term)   cnt <= cnt + 1'b1;
  end

  // R9
  paused_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !run) |=> $stable(cnt));

  // R4
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (at_term && !clr) |=> (cnt == TERM));

endmodule

// File: rtl/chg_seq_fsm.sv
module chg_seq_fsm
  import chg_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       src_ok,
  input  logic       in_vreg,
  input  logic       below_taper,
  input  logic       below_term,
  input  logic       below_rch,
  input  logic       timer_en,
  input  logic       chg_reset,
  input  logic       safe_exp,
  input  logic       taper_exp,
  output chg_state_e state,
  output logic       st_taper,
  output logic       st_term,
  output logic       st_fault,
  output logic       safe_clr,
  output logic       taper_clr
);

  chg_state_e nxt;
  logic set_taper, set_term, set_fault, clr_done;
  logic safe_hit, taper_hit;

  assign safe_hit  = timer_en && safe_exp;
  assign taper_hit = timer_en && taper_exp;

  // Safety timer restarts when leaving regulation or when not charging.
  assign safe_clr  = !timer_en || !is_charging(state) ||
                     (in_reg_phase(state) && !in_vreg);
  assign taper_clr = !timer_en || (state != ST_TAPER);

  always_comb begin
    nxt       = state;
    set_taper = 1'b0;
    set_term  = 1'b0;
    set_fault = 1'b0;
    clr_done  = 1'b0;
    if (chg_reset) begin
      nxt = ST_SLEEP;
    end else if (state == ST_FAULT) begin
      nxt = ST_FAULT;
    end else if (!src_ok) begin
      nxt = ST_SLEEP;
    end else begin
      unique case (state)
        ST_SLEEP: nxt = ST_FAST;
        ST_FAST: begin
          if (below_term)    begin nxt = ST_DONE;  set_term = 1'b1;  end
          else if (safe_hit) begin nxt = ST_FAULT; set_fault = 1'b1; end
          else if (in_vreg)        nxt = ST_VREG;
        end
        ST_VREG: begin
          if (below_term)       begin nxt = ST_DONE;  set_term = 1'b1;  end
          else if (safe_hit)    begin nxt = ST_FAULT; set_fault = 1'b1; end
          else if (!in_vreg)          nxt = ST_FAST;
          else if (below_taper)       nxt = ST_TAPER;
        end
        ST_TAPER: begin
          if (below_term)        begin nxt = ST_DONE; set_term = 1'b1;  end
          else if (!in_vreg)           nxt = ST_FAST;
          else if (!below_taper)       nxt = ST_VREG;
          else if (taper_hit)    begin nxt = ST_DONE; set_taper = 1'b1; end
        end
        ST_DONE: begin
          if (below_rch) begin nxt = ST_FAST; clr_done = 1'b1; end
        end
        default: nxt = ST_SLEEP;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_SLEEP;
      st_taper <= 1'b0;
      st_term  <= 1'b0;
      st_fault <= 1'b0;
    end else begin
      state <= nxt;
      if (chg_reset) begin
        st_taper <= 1'b0;
        st_term  <= 1'b0;
        st_fault <= 1'b0;
      end else begin
        if (set_fault) st_fault <= 1'b1;
        if (set_term)  st_term  <= 1'b1;
        if (set_taper) st_taper <= 1'b1;
        if (clr_done) begin
          st_taper <= 1'b0;
          st_term  <= 1'b0;
        end
      end
    end
  end

  // R5
  fault_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_FAULT) && !chg_reset) |=> ((state == ST_FAULT) && st_fault));

  // R2
  sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!src_ok && !chg_reset && (state != ST_FAULT)) |=> (state == ST_SLEEP));

  // R7
  term_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_charging(state) && src_ok && below_term && !chg_reset)
      |=> ((state == ST_DONE) && st_term));

  // R10
  recharge_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_DONE) && src_ok && below_rch && !chg_reset)
      |=> ((state == ST_FAST) && !st_taper && !st_term));

  // R11
  chg_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chg_reset |=> ((state == ST_SLEEP) && !st_fault && !st_taper && !st_term));

endmodule

// File: rtl/chg_seq_pg.sv
module chg_seq_pg
  import chg_seq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            src_ok,
  input  logic            chg_reset,
  input  logic [1:0]      mode,
  input  logic [PG_W-1:0] on_time,
  input  logic [PG_W-1:0] period,
  output logic            pg_on,
  output logic            pg_hiz
);

  pg_mode_e        mode_e;
  logic [PG_W-1:0] blink_cnt;
  logic            lit;

  assign mode_e = pg_mode_e'(mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  blink_cnt <= '0;
    else if (mode_e != PG_BLINK) blink_cnt <= '0;
    else if (tick)               blink_cnt <= blink_step(blink_cnt, period);
  end

  always_comb begin
    unique case (mode_e)
      PG_FOLLOW:    lit = src_ok;
      PG_FORCE_ON:  lit = 1'b1;
      PG_FORCE_OFF: lit = 1'b0;
      default:      lit = blink_lit(blink_cnt, on_time);
    endcase
  end

  assign pg_hiz = chg_reset;
  assign pg_on  = lit && !chg_reset;

  // R12
  blink_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_e != PG_BLINK) |=> (blink_cnt == '0));

endmodule

// File: rtl/chg_seq.sv
module chg_seq
  import chg_seq_pkg::*;
#(
  parameter int TMR_W = 16,
  parameter int unsigned SAFE_TICKS = 1000,
  parameter int unsigned TAPER_TICKS = 100
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            ac_present,
  input  logic            ac_ovp,
  input  logic            usb_present,
  input  logic            in_vreg,
  input  logic            below_taper,
  input  logic            below_term,
  input  logic            below_rch,
  input  logic            therm_susp,
  input  logic            cfg_timer_en,
  input  logic            cfg_chg_reset,
  input  logic [1:0]      pg_mode,
  input  logic [PG_W-1:0] pg_on_time,
  input  logic [PG_W-1:0] pg_period,
  output logic            chg_en,
  output logic            det_cur_sel,
  output logic [2:0]      state_o,
  output logic            st_taper,
  output logic            st_term,
  output logic            st_fault,
  output logic            irq,
  output logic            pg_on,
  output logic            pg_hiz
);

  chg_state_e state;
  logic src_ok, tmr_run;
  logic safe_clr, taper_clr, safe_exp, taper_exp;

  assign src_ok  = (ac_present && !ac_ovp) || usb_present;
  assign tmr_run = cfg_timer_en && tick && !therm_susp;

  chg_seq_timer #(.W(TMR_W), .LIMIT(SAFE_TICKS)) u_safe_tmr (
    .clk(clk), .rst_n(rst_n), .clr(safe_clr), .run(tmr_run), .expired(safe_exp)
  );

  chg_seq_timer #(.W(TMR_W), .LIMIT(TAPER_TICKS)) u_taper_tmr (
    .clk(clk), .rst_n(rst_n), .clr(taper_clr), .run(tmr_run), .expired(taper_exp)
  );

  chg_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .src_ok(src_ok), .in_vreg(in_vreg),
    .below_taper(below_taper), .below_term(below_term), .below_rch(below_rch),
    .timer_en(cfg_timer_en), .chg_reset(cfg_chg_reset),
    .safe_exp(safe_exp), .taper_exp(taper_exp),
    .state(state), .st_taper(st_taper), .st_term(st_term), .st_fault(st_fault),
    .safe_clr(safe_clr), .taper_clr(taper_clr)
  );

  chg_seq_pg u_pg (
    .clk(clk), .rst_n(rst_n), .tick(tick), .src_ok(src_ok),
    .chg_reset(cfg_chg_reset), .mode(pg_mode), .on_time(pg_on_time),
    .period(pg_period), .pg_on(pg_on), .pg_hiz(pg_hiz)
  );

  assign state_o     = state;
  assign chg_en      = is_charging(state);
  assign det_cur_sel = (state == ST_FAULT);
  assign irq         = st_taper || st_term || st_fault;

  // R5
  fault_current_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_fault |-> (!chg_en || cfg_chg_reset || $rose(st_fault) || !det_cur_sel));

endmodule

// File: tb/chg_seq_bench.sv
module chg_seq_bench;
  localparam int SAFE = 40;
  localparam int TAPR = 4;
  localparam int PGW  = chg_seq_pkg::PG_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, ac = 1'b0, ovp = 1'b0, usb = 1'b0, vreg = 1'b0;
  logic btap = 1'b0, bterm = 1'b0, brch = 1'b0, therm = 1'b0;
  logic ten = 1'b1, creset = 1'b0;
  logic [1:0] pmode = 2'd0;
  logic [PGW-1:0] pon = 8'd2, pper = 8'd5;
  logic chg_en, det_cur_sel, st_taper, st_term, st_fault, irq, pg_on, pg_hiz;
  logic [2:0] state_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  chg_seq #(.SAFE_TICKS(SAFE), .TAPER_TICKS(TAPR)) u_chg_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ac_present(ac), .ac_ovp(ovp),
    .usb_present(usb), .in_vreg(vreg), .below_taper(btap), .below_term(bterm),
    .below_rch(brch), .therm_susp(therm), .cfg_timer_en(ten),
    .cfg_chg_reset(creset), .pg_mode(pmode), .pg_on_time(pon), .pg_period(pper),
    .chg_en(chg_en), .det_cur_sel(det_cur_sel), .state_o(state_o),
    .st_taper(st_taper), .st_term(st_term), .st_fault(st_fault), .irq(irq),
    .pg_on(pg_on), .pg_hiz(pg_hiz)
  );

  // Reference model, written from the requirements.
  int ms = 0, msafe = 0, mtap = 0, mblink = 0;
  bit mta = 0, mte = 0, mfa = 0;

  function automatic bit valid_src();
    return (ac && !ovp) || usb;
  endfunction

  function automatic bit charging_code(int s);
    return s >= 1 && s <= 3;
  endfunction

  function automatic bit exp_pg();
    if (creset) return 1'b0;
    case (pmode)
      2'd0: return valid_src();
      2'd1: return 1'b1;
      2'd2: return 1'b0;
      default: return mblink < int'(pon);
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ms = 0; msafe = 0; mtap = 0; mblink = 0; mta = 0; mte = 0; mfa = 0;
    end else begin
      int ns, nsafe, ntap;
      bit sx, tx, src;
      src = valid_src();
      sx = ten && (msafe == SAFE);
      tx = ten && (mtap == TAPR);
      // timers (R4, R8, R9, R3)
      if (!ten || !charging_code(ms) || ((ms == 2 || ms == 3) && !vreg)) nsafe = 0;
      else if (tick && !therm && msafe < SAFE) nsafe = msafe + 1;
      else nsafe = msafe;
      if (!ten || ms != 3) ntap = 0;
      else if (tick && !therm && mtap < TAPR) ntap = mtap + 1;
      else ntap = mtap;
      ns = ms;
      if (creset) begin
        ns = 0; mta = 0; mte = 0; mfa = 0;
      end else if (ms == 5) ns = 5;
      else if (!src) ns = 0;
      else if (ms == 0) ns = 1;
      else if (ms == 4) begin
        if (brch) begin ns = 1; mta = 0; mte = 0; end
      end else if (bterm) begin ns = 4; mte = 1; end
      else if (ms != 3 && sx) begin ns = 5; mfa = 1; end
      else if (ms == 1) begin if (vreg) ns = 2; end
      else if (!vreg) ns = 1;
      else if (ms == 2) begin if (btap) ns = 3; end
      else if (!btap) ns = 2;
      else if (tx) begin ns = 4; mta = 1; end
      ms = ns; msafe = nsafe; mtap = ntap;
      // blink counter (R12)
      if (pmode != 2'd3) mblink = 0;
      else if (tick) mblink = (mblink + 1 >= int'(pper)) ? 0 : mblink + 1;
    end
  end

  task automatic compare_all();
    logic [10:0] act, expv;
    act  = {state_o, chg_en, det_cur_sel, st_taper, st_term, st_fault, irq, pg_on, pg_hiz};
    expv = {3'(ms), charging_code(ms), ms == 5, mta, mte, mfa, mta | mte | mfa,
            exp_pg(), creset};
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s outputs actual=%h expected=%h at %0t", cur_req, act, expv, $time);
    end
  endtask

  task automatic check_bit(logic a, logic e, string req, string what);
    checks++;
    if (a !== e) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, a, e);
    end
  endtask

  task automatic check_state(int e, string req);
    checks++;
    if (int'(state_o) != e) begin
      fails++;
      $display("FAIL %s state actual=%0d expected=%0d", req, state_o, e);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
      compare_all();
    end
  endtask

  initial begin
    int lit;
    void'($urandom(32'd20240611));
    tick = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    check_state(0, "R1");
    check_bit(irq, 1'b0, "R1", "irq");
    rst_n = 1'b1;
    cyc(2);
    check_state(0, "R1");
    // R2: overvoltage AC is not a valid source
    cur_req = "R2"; ac = 1'b1; ovp = 1'b1; cyc(3);
    check_state(0, "R2");
    ovp = 1'b0; cyc(2);
    check_state(1, "R2");
    // R4: safety timer fault in FAST
    cur_req = "R4"; cyc(SAFE + 5);
    check_state(5, "R4");
    check_bit(det_cur_sel, 1'b1, "R4", "det_cur_sel");
    // R5: fault persists with any inputs
    cur_req = "R5"; ac = 1'b0; vreg = 1'b1; bterm = 1'b1; brch = 1'b1; cyc(6);
    check_state(5, "R5");
    check_bit(chg_en, 1'b0, "R5", "chg_en");
    // R11: charger reset
    cur_req = "R11"; creset = 1'b1; cyc(1);
    check_bit(pg_hiz, 1'b1, "R11", "pg_hiz");
    cyc(1);
    check_state(0, "R11");
    check_bit(st_fault, 1'b0, "R11", "st_fault");
    creset = 1'b0; bterm = 1'b0; brch = 1'b0; usb = 1'b1; cyc(3);
    check_state(2, "R3");
    // R3: leaving regulation restarts safety timer; no fault over many cycles
    cur_req = "R3";
    for (int i = 0; i < 8; i++) begin
      cyc(30); vreg = 1'b0; cyc(1); vreg = 1'b1;
    end
    cyc(1);
    check_state(2, "R3");
    // R6: taper with a bounce back to VREG
    cur_req = "R6"; vreg = 1'b0; cyc(1); vreg = 1'b1; cyc(1);
    btap = 1'b1; cyc(3);
    check_state(3, "R6");
    btap = 1'b0; cyc(1);
    check_state(2, "R6");
    btap = 1'b1; cyc(TAPR + 3);
    check_state(4, "R6");
    check_bit(st_taper, 1'b1, "R6", "st_taper");
    // R10: recharge clears status
    cur_req = "R10"; btap = 1'b0; brch = 1'b1; cyc(1);
    check_state(1, "R10");
    check_bit(irq, 1'b0, "R10", "irq");
    brch = 1'b0;
    // R9: thermal suspend freezes taper timer
    cur_req = "R9"; cyc(1); btap = 1'b1; cyc(2);
    therm = 1'b1; cyc(12);
    check_state(3, "R9");
    therm = 1'b0; cyc(TAPR + 1);
    check_state(4, "R9");
    // R7: minimum-current termination
    cur_req = "R7"; btap = 1'b0; vreg = 1'b0; brch = 1'b1; cyc(1); brch = 1'b0;
    bterm = 1'b1; cyc(1);
    check_state(4, "R7");
    check_bit(st_term, 1'b1, "R7", "st_term");
    bterm = 1'b0;
    // R8: timers disabled
    cur_req = "R8"; ten = 1'b0; brch = 1'b1; cyc(1); brch = 1'b0;
    vreg = 1'b1; btap = 1'b1; cyc(80);
    check_state(3, "R8");
    vreg = 1'b0; cyc(80);
    check_state(1, "R8");
    ten = 1'b1; btap = 1'b0;
    // R12: power-good modes
    cur_req = "R12"; pmode = 2'd1; usb = 1'b0; cyc(2);
    check_bit(pg_on, 1'b1, "R12", "pg forced on");
    check_state(0, "R2");
    pmode = 2'd2; usb = 1'b1; cyc(2);
    check_bit(pg_on, 1'b0, "R12", "pg forced off");
    pmode = 2'd0; cyc(1);
    check_bit(pg_on, 1'b1, "R12", "pg follow");
    pmode = 2'd3; pon = 8'd2; pper = 8'd5;
    lit = 0;
    for (int i = 0; i < 10; i++) begin
      lit += int'(pg_on);
      cyc(1);
    end
    checks++;
    if (lit != 4) begin
      fails++;
      $display("FAIL R12 blink on-count actual=%0d expected=4", lit);
    end
    // random phase
    cur_req = "R4";
    for (int i = 0; i < 6000; i++) begin
      tick = ($urandom_range(0, 1) == 0);
      if ($urandom_range(0, 15) == 0) vreg = ~vreg;
      if ($urandom_range(0, 15) == 0) btap = ~btap;
      if ($urandom_range(0, 40) == 0) bterm = ~bterm;
      if ($urandom_range(0, 30) == 0) brch = ~brch;
      if ($urandom_range(0, 30) == 0) therm = ~therm;
      if ($urandom_range(0, 60) == 0) usb = ~usb;
      if ($urandom_range(0, 60) == 0) ac = ~ac;
      if ($urandom_range(0, 60) == 0) ovp = ~ovp;
      if ($urandom_range(0, 200) == 0) ten = ~ten;
      creset = ($urandom_range(0, 300) == 0);
      if ($urandom_range(0, 150) == 0) pmode = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 300) == 0) begin
        pon = 8'($urandom_range(0, 6)); pper = 8'($urandom_range(0, 8));
      end
      cyc(1);
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired in %s", cur_req);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule